// File: doc/BRIEF.md
# Byte-Programmed Multiply, Divide and Accumulate Engine

The engine is a small arithmetic coprocessor that a processor drives with byte-wide register writes. Software picks an operation in a control register, loads two 16-bit operands one byte at a time, and starts the operation by writing the upper byte of the second operand. No separate start command exists. The engine offers three operations: a signed 16x16 multiply, a division of a signed dividend by an unsigned divisor, and a signed multiply-accumulate into a 40-bit running sum. All three operations write the same 40-bit result register.

Multiply and multiply-accumulate complete in the cycle of the triggering write. Division runs one quotient bit per clock, and a busy flag stays raised for the whole division. While the engine is busy it ignores all writes. Reads during that time return the result of the previous operation. After each operation the engine clears the operands that the operation consumed, so software only rewrites what changes between operations. The result, the status byte, the operands and the mode can all be read back through a registered byte read port.

Top module: `arith_engine`

## Requirements
- R1: After synchronous reset, every readable location returns 0 and busy is low.
- R2: Write select 0 is the control register, and its bits 1:0 set the mode (0 multiply, 1 divide, 2 or 3 multiply-accumulate). Writing it with bit 1 set clears the 40-bit result to zero. The mode reads back at read select 10.
- R3: Write selects 1/2 load the low/high byte of operand A and 3/4 load the low/high byte of operand B. Only a write to select 4 starts an operation, and writes to selects 1 to 3 leave the result unchanged.
- R4: In multiply mode, the trigger stores the signed product A*B, sign-extended to 40 bits, in the result. It clears B and keeps A.
- R5: In divide mode, A is signed and B unsigned. The quotient truncates toward zero and goes in result bits 15:0. The remainder takes the sign of A, truncated to 16 bits, and goes in bits 31:16. Bits 39:32 are zero. A and B are both cleared.
- R6: A division by a B of zero writes a result of 0 in the trigger cycle and does not raise busy.
- R7: In multiply-accumulate mode, the signed product is added to the 40-bit result. The overflow flag is set when the true sum falls outside 0 to 2^40-1 and cleared otherwise, and the sum wraps to 40 bits. Only this mode changes the overflow flag. B is cleared and A is kept.
- R8: A nonzero division keeps busy high for exactly 16 cycles. While busy, writes are ignored and the result keeps its previous value.
- R9: rd_byte shows, one cycle after rd_sel, the selected location: selects 0-4 are result bytes from least to most significant, 5 is status (bit 0 overflow, bit 7 busy), 6/7 are A low/high, 8/9 are B low/high, 10 is the mode, and all others return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 3 | Write register select |
| wr_byte | input | 8 | Write data |
| rd_sel | input | 4 | Read location select |
| rd_byte | output | 8 | Registered read data |
| busy | output | 1 | Division in progress |

## Verification
The bound checker checks these behaviours on every cycle:
- the busy window is never longer than 16 cycles;
- the result stays frozen while a division runs;
- the operands and mode ignore writes during busy;
- a division that starts has already cleared both operands;
- the overflow flag moves only after an accumulate trigger;
- a division by zero never raises busy;
- unmapped read selects return zero.

The arithmetic values themselves can only be shown by the bench's scenarios. These include signed products at the operand extremes, divisions with negative dividends and divisors above 32767, the wrap of the accumulator at exactly 2^40 after 1024 accumulations, and the exact 16-cycle latency of a division.

// File: rtl/arith_engine_pkg.sv
package arith_engine_pkg;

  typedef enum logic [1:0] {
    MODE_MUL     = 2'd0,
    MODE_DIV     = 2'd1,
    MODE_MAC     = 2'd2,
    MODE_MAC_ALT = 2'd3
  } mode_e;

  localparam int WSEL_W = 3;
  localparam logic [WSEL_W-1:0] WSEL_CTRL = 3'd0;
  localparam logic [WSEL_W-1:0] WSEL_A_LO = 3'd1;
  localparam logic [WSEL_W-1:0] WSEL_A_HI = 3'd2;
  localparam logic [WSEL_W-1:0] WSEL_B_LO = 3'd3;
  localparam logic [WSEL_W-1:0] WSEL_B_HI = 3'd4;

  localparam int CTRL_CLR_BIT = 1;
  localparam int STAT_OVF_BIT = 0;
  localparam int STAT_BUSY_BIT = 7;

endpackage

// File: rtl/arith_mul.sv
module arith_mul #(
  parameter int W = 16
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  // Two's-complement product of two signed operands.
  assign p = $signed(a) * $signed(b);
endmodule

// File: rtl/arith_divider.sv
module arith_divider #(
  parameter int W = 16,
  localparam int CNT_W = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         last,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  logic             neg_q;
  logic [W-1:0]     sh_q;
  logic [W-1:0]     rem_q;
  logic [W-1:0]     dvs_q;
  logic [CNT_W-1:0] cnt_q;

  logic [W:0]   trial;
  logic         ge;
  logic [W-1:0] rem_nx;
  logic [W-1:0] sh_nx;

  // One restoring step per cycle on the dividend magnitude.
  always_comb begin
    trial  = {rem_q, sh_q[W-1]};
    ge     = trial >= {1'b0, dvs_q};
    rem_nx = ge ? (trial[W-1:0] - dvs_q) : trial[W-1:0];
    sh_nx  = {sh_q[W-2:0], ge};
  end

  // Final values are taken from the step that ends the division.
  assign last = busy && (cnt_q == CNT_W'(1));
  assign quo  = neg_q ? -sh_nx : sh_nx;
  assign rem  = neg_q ? -rem_nx : rem_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      neg_q <= 1'b0;
      sh_q  <= '0;
      rem_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
    end else if (start && !busy) begin
      neg_q <= dividend[W-1];
      sh_q  <= dividend[W-1] ? -dividend : dividend;
      rem_q <= '0;
      dvs_q <= divisor;
      cnt_q <= CNT_W'(W);
      busy  <= 1'b1;
    end else if (busy) begin
      sh_q  <= sh_nx;
      rem_q <= rem_nx;
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/arith_readout.sv
module arith_readout #(
  parameter int OP_W   = 16,
  parameter int ACC_W  = 40,
  parameter int RSEL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RSEL_W-1:0] rd_sel,
  input  logic [ACC_W-1:0]  acc,
  input  logic              ovf,
  input  logic              busy,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  input  logic [1:0]        mode,
  output logic [7:0]        rd_byte
);
  localparam int ACC_BYTES = ACC_W / 8;
  localparam int SEL_STAT  = ACC_BYTES;
  localparam int SEL_A_LO  = ACC_BYTES + 1;
  localparam int SEL_A_HI  = ACC_BYTES + 2;
  localparam int SEL_B_LO  = ACC_BYTES + 3;
  localparam int SEL_B_HI  = ACC_BYTES + 4;
  localparam int SEL_MODE  = ACC_BYTES + 5;

  logic [7:0] mux;

  always_comb begin
    mux = '0;
    for (int i = 0; i < ACC_BYTES; i++) begin
      if (rd_sel == RSEL_W'(i)) mux = acc[i*8 +: 8];
    end
    if (rd_sel == RSEL_W'(SEL_STAT)) begin
      mux[0] = ovf;
      mux[7] = busy;
    end
    if (rd_sel == RSEL_W'(SEL_A_LO)) mux = op_a[7:0];
    if (rd_sel == RSEL_W'(SEL_A_HI)) mux = op_a[OP_W-1:8];
    if (rd_sel == RSEL_W'(SEL_B_LO)) mux = op_b[7:0];
    if (rd_sel == RSEL_W'(SEL_B_HI)) mux = op_b[OP_W-1:8];
    if (rd_sel == RSEL_W'(SEL_MODE)) mux = {6'd0, mode};
  end

  always_ff @(posedge clk) begin
    if (rst) rd_byte <= '0;
    else     rd_byte <= mux;
  end
endmodule

// File: rtl/arith_engine.sv
module arith_engine
  import arith_engine_pkg::*;
#(
  parameter int OP_W   = 16,
  parameter int ACC_W  = 40,
  parameter int RSEL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WSEL_W-1:0] wr_sel,
  input  logic [7:0]        wr_byte,
  input  logic [RSEL_W-1:0] rd_sel,
  output logic [7:0]        rd_byte,
  output logic              busy
);
  localparam int PROD_W = 2 * OP_W;
  localparam int PAD_W  = ACC_W - PROD_W;

  mode_e            mode_q;
  logic [OP_W-1:0]  op_a_q;
  logic [OP_W-1:0]  op_b_q;
  logic [ACC_W-1:0] acc_q;
  logic             ovf_q;

  logic             wr_ok;
  logic             trig;
  logic [OP_W-1:0]  b_next;
  logic [PROD_W-1:0] prod;
  logic [ACC_W+1:0] mac_sum;
  logic             div_start;
  logic             div_last;
  logic [OP_W-1:0]  div_quo;
  logic [OP_W-1:0]  div_rem;

  assign wr_ok     = wr_en && !busy;
  assign trig      = wr_ok && (wr_sel == WSEL_B_HI);
  assign b_next    = {wr_byte, op_b_q[7:0]};
  assign div_start = trig && (mode_q == MODE_DIV) && (b_next != '0);
  assign mac_sum   = {2'b00, acc_q} + {{(PAD_W + 2){prod[PROD_W-1]}}, prod};

  arith_mul #(.W(OP_W)) u_mul (
    .a (op_a_q),
    .b (b_next),
    .p (prod)
  );

  arith_divider #(.W(OP_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (div_start),
    .dividend (op_a_q),
    .divisor  (b_next),
    .busy     (busy),
    .last     (div_last),
    .quo      (div_quo),
    .rem      (div_rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_MUL;
      op_a_q <= '0;
      op_b_q <= '0;
      acc_q  <= '0;
      ovf_q  <= 1'b0;
    end else if (div_last) begin
      acc_q <= {{PAD_W{1'b0}}, div_rem, div_quo};
    end else if (wr_ok) begin
      case (wr_sel)
        WSEL_CTRL: begin
          mode_q <= mode_e'(wr_byte[1:0]);
          if (wr_byte[CTRL_CLR_BIT]) acc_q <= '0;
        end
        WSEL_A_LO: op_a_q[7:0]      <= wr_byte;
        WSEL_A_HI: op_a_q[OP_W-1:8] <= wr_byte;
        WSEL_B_LO: op_b_q[7:0]      <= wr_byte;
        WSEL_B_HI: begin
          op_b_q <= '0;
          case (mode_q)
            MODE_MUL: acc_q <= {{PAD_W{prod[PROD_W-1]}}, prod};
            MODE_DIV: begin
              op_a_q <= '0;
              if (b_next == '0) acc_q <= '0;
            end
            default: begin
              acc_q <= mac_sum[ACC_W-1:0];
              ovf_q <= |mac_sum[ACC_W+1:ACC_W];
            end
          endcase
        end
        default: ;
      endcase
    end
  end

  arith_readout #(.OP_W(OP_W), .ACC_W(ACC_W), .RSEL_W(RSEL_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_sel  (rd_sel),
    .acc     (acc_q),
    .ovf     (ovf_q),
    .busy    (busy),
    .op_a    (op_a_q),
    .op_b    (op_b_q),
    .mode    (mode_q),
    .rd_byte (rd_byte)
  );
endmodule

// File: rtl/arith_engine_chk.sv
module arith_engine_chk #(
  parameter int OP_W   = 16,
  parameter int ACC_W  = 40,
  parameter int RSEL_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [2:0]        wr_sel,
  input logic [7:0]        wr_byte,
  input logic [RSEL_W-1:0] rd_sel,
  input logic [7:0]        rd_byte,
  input logic              busy,
  input logic              ovf,
  input logic [ACC_W-1:0]  acc,
  input logic [OP_W-1:0]   op_a,
  input logic [OP_W-1:0]   op_b,
  input logic [1:0]        mode
);
  localparam int LAST_SEL = ACC_W / 8 + 5;

  logic [15:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (rst)       busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 16'd1;
    else           busy_cnt <= '0;
  end

  // R8: the division window never exceeds one cycle per quotient bit
  assert_busy_len_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_cnt < 16'(OP_W)));

  // R8: result is frozen inside a division
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy) |-> $stable(acc));

  // R8: writes while busy touch no register
  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en) |=> ($stable(op_a) && $stable(op_b) && $stable(mode)));

  // R5: a started division has consumed both operands
  assert_div_clears_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (op_a == '0 && op_b == '0));

  // R6: division by zero never goes busy
  assert_div0_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy && wr_sel == 3'd4 && mode == 2'd1 &&
     op_b[7:0] == 8'd0 && wr_byte == 8'd0) |=> !busy);

  // R7: overflow flag moves only after an accumulate trigger
  assert_ovf_mac_only_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(ovf) |-> $past(wr_en && !busy && wr_sel == 3'd4 && mode[1]));

  // R9: unmapped read selects return zero
  assert_unmapped_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_sel) > RSEL_W'(LAST_SEL)) |-> (rd_byte == 8'd0));
endmodule

bind arith_engine arith_engine_chk #(.OP_W(OP_W), .ACC_W(ACC_W), .RSEL_W(RSEL_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_sel  (wr_sel),
  .wr_byte (wr_byte),
  .rd_sel  (rd_sel),
  .rd_byte (rd_byte),
  .busy    (busy),
  .ovf     (ovf_q),
  .acc     (acc_q),
  .op_a    (op_a_q),
  .op_b    (op_b_q),
  .mode    (mode_q)
);

// File: tb/test_arith_engine.sv
module test_arith_engine;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_byte = '0;
  logic [3:0] rd_sel = '0;
  logic [7:0] rd_byte;
  logic       busy;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  arith_engine i_arith_engine (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_byte(wr_byte),
    .rd_sel(rd_sel), .rd_byte(rd_byte), .busy(busy)
  );

  // {mode, A, B, expected result, overflow checked, expected overflow}
  localparam int NV = 13;
  localparam logic [75:0] VECS [0:NV-1] = '{
    {2'd0, 16'h0003, 16'h0005, 40'h000000000F, 1'b0, 1'b0},
    {2'd0, 16'hFFFE, 16'h0003, 40'hFFFFFFFFFA, 1'b0, 1'b0},
    {2'd0, 16'h8000, 16'h8000, 40'h0040000000, 1'b0, 1'b0},
    {2'd0, 16'h7FFF, 16'hFFFF, 40'hFFFFFF8001, 1'b0, 1'b0},
    {2'd1, 16'd100,  16'd7,    40'h000002000E, 1'b0, 1'b0},
    {2'd1, 16'hFFF9, 16'd2,    40'h00FFFFFFFD, 1'b0, 1'b0},
    {2'd1, 16'd1000, 16'hFFFF, 40'h0003E80000, 1'b0, 1'b0},
    {2'd1, 16'h8000, 16'd1,    40'h0000008000, 1'b0, 1'b0},
    {2'd1, 16'h8000, 16'hFFFF, 40'h0080000000, 1'b0, 1'b0},
    {2'd1, 16'd5,    16'd0,    40'h0000000000, 1'b0, 1'b0},
    {2'd1, 16'hFF9C, 16'h8000, 40'h00FF9C0000, 1'b0, 1'b0},
    {2'd2, 16'd100,  16'd200,  40'h0000004E20, 1'b1, 1'b0},
    {2'd3, 16'hFFFF, 16'h0001, 40'hFFFFFFFFFF, 1'b1, 1'b1}
  };

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_byte = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] s, output logic [7:0] d);
    @(negedge clk); rd_sel = s;
    @(negedge clk); d = rd_byte;
  endtask

  task automatic rd_res(output logic [39:0] r);
    logic [7:0] b;
    for (int i = 0; i < 5; i++) begin
      rd(4'(i), b);
      r[i*8 +: 8] = b;
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [15:0] a, input logic [15:0] b);
    wr(3'd1, a[7:0]); wr(3'd2, a[15:8]); wr(3'd3, b[7:0]); wr(3'd4, b[15:8]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [39:0] r;
    logic [7:0]  b;
    int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int s = 0; s <= 10; s++) begin
      rd(4'(s), b);
      check($sformatf("R1 sel%0d", s), 40'(b), 40'h0);
    end
    check("R1 busy", 40'(busy), 40'h0);

    // Vector table: R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      wr(3'd0, {6'd0, VECS[v][75:74]});
      load(VECS[v][73:58], VECS[v][57:42]);
      wait_idle();
      rd_res(r);
      check($sformatf("R4/R5/R7 vec%0d", v), r, VECS[v][41:2]);
      if (VECS[v][1]) begin
        rd(4'd5, b);
        check($sformatf("R7 ovf vec%0d", v), 40'(b[0]), 40'(VECS[v][0]));
      end
    end

    // R3: only the B high byte triggers
    wr(3'd0, 8'd0);
    wr(3'd1, 8'h02); wr(3'd2, 8'h00); wr(3'd3, 8'h03);
    rd_res(r);
    check("R3 no trigger on low bytes", r, 40'hFFFFFFFFFF);
    wr(3'd4, 8'h00);
    rd_res(r);
    check("R3 trigger on B high", r, 40'h6);

    // R4: A kept, B cleared after multiply
    rd(4'd6, b); check("R4 A kept", 40'(b), 40'h02);
    rd(4'd8, b); check("R4 B lo cleared", 40'(b), 40'h0);

    // R2: clear via control bit 1 and mode readback
    wr(3'd0, 8'h03);
    rd_res(r); check("R2 clear", r, 40'h0);
    rd(4'd10, b); check("R2 mode", 40'(b), 40'h3);

    // R7: 1024 accumulations of 2^30 wrap exactly at 2^40
    wr(3'd0, 8'h02);
    wr(3'd1, 8'h00); wr(3'd2, 8'h80);
    for (int k = 0; k < 1023; k++) begin
      wr(3'd3, 8'h00); wr(3'd4, 8'h80);
    end
    rd_res(r); check("R7 sum before wrap", r, 40'hFFC0000000);
    rd(4'd5, b); check("R7 no ovf before wrap", 40'(b[0]), 40'h0);
    wr(3'd3, 8'h00); wr(3'd4, 8'h80);
    rd_res(r); check("R7 wrapped", r, 40'h0);
    rd(4'd5, b); check("R7 ovf set", 40'(b[0]), 40'h1);
    rd(4'd7, b); check("R7 A kept", 40'(b), 40'h80);
    rd(4'd9, b); check("R7 B cleared", 40'(b), 40'h0);

    // R7: multiply leaves overflow untouched
    wr(3'd0, 8'h00);
    wr(3'd3, 8'h02); wr(3'd4, 8'h00);
    rd(4'd5, b); check("R7 ovf kept by multiply", 40'(b[0]), 40'h1);
    rd_res(r); check("R4 -32768*2", r, 40'hFFFFFF0000);

    // R8: exact division latency
    wr(3'd0, 8'h01);
    wr(3'd1, 8'd100); wr(3'd2, 8'd0); wr(3'd3, 8'd7);
    wr(3'd4, 8'd0);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check("R8 busy cycles", 40'(n), 40'd16);
    rd_res(r); check("R5 100/7", r, 40'h000002000E);

    // R8: reads during busy see old result, writes ignored
    load(16'hFFF9, 16'd2);
    rd(4'd5, b); check("R8 status busy bit", 40'(b[7]), 40'h1);
    rd(4'd0, b); check("R8 old result during busy", 40'(b), 40'h0E);
    wr(3'd1, 8'h55);
    wait_idle();
    rd(4'd6, b); check("R8 write ignored while busy", 40'(b), 40'h0);
    rd_res(r); check("R5 -7/2", r, 40'h00FFFFFFFD);

    // R6: divide by zero never busy
    wr(3'd1, 8'd9); wr(3'd3, 8'd0); wr(3'd4, 8'd0);
    check("R6 not busy", 40'(busy), 40'h0);
    rd_res(r); check("R6 zero result", r, 40'h0);

    // R9: unmapped selects
    rd(4'd11, b); check("R9 sel11", 40'(b), 40'h0);
    rd(4'd15, b); check("R9 sel15", 40'(b), 40'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule